// File: doc/BRIEF.md
# Time-Slotted Synchronous Serial Port

This block connects a processing core to codecs or other processors over a synchronous serial link that carries a bit clock, a frame sync and data lines. It has one receiver and several transmitters (three by default). Each transmitter has one holding word that the core writes through a plain parallel strobe. The receiver hands every completed word to the core as a one-cycle pulse, together with the number of the slot it arrived in. The serial clock and frame sync are slave inputs. The block samples them with its own system clock and acts on their edges, so the serial clock must run well below the system clock.

Two settings are independent of each other. The frame setting picks normal mode, with one word per frame, or network mode, with up to 32 time slots per frame. In network mode a per-slot mask enables each transmitter and the receiver slot by slot. The channel setting picks synchronous mode, where every transmitter uses the receive clock and frame sync, or asynchronous mode, where the transmit side uses its own clock and sync pins and only transmitter 0 may drive. Each transmit line has its own output enable, which a pad tristate buffer uses to release the line in slots the transmitter does not own.

Top module: `tdm_serial_port`

## Requirements
- R1: After reset, every tx_sd_o, tx_oe_o, tx_load_o and tx_urun_o bit is 0, and rx_valid_o is 0.
- R2: Transmit data changes only on a rising bit-clock edge and leaves most significant bit first. The receiver samples on the falling edge. A frame sync seen high on a falling edge makes the next bit period bit 0 of slot 0.
- R3: wlen_sel_i selects the word and slot length: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 24 bits. A transmitter sends the low bits of its word, and rx_word_o holds the received word right-aligned with its upper bits at zero.
- R4: In normal mode (net_mode_i=0) a frame holds exactly one slot, slot 0, and the slot masks have no effect. After that word the transmit outputs are idle (oe=0, sd=0) until the next frame sync.
- R5: In network mode a frame holds last_slot_i+1 consecutive slots, numbered from 0.
- R6: In network mode, transmitter k drives a slot s (tx_oe_o[k]=1) only if bit k*32+s of tx_mask_i is set. The receiver reports slot s only if bit s of rx_mask_i is set.
- R7: In synchronous mode (async_i=0) all transmitters use rx_sck_i and rx_fs_i, all three may drive in one frame, and tx_sck_i and tx_fs_i are ignored.
- R8: In asynchronous mode (async_i=1) the transmit side uses tx_sck_i and tx_fs_i, and transmitters 1 and up never drive.
- R9: A tx_wr_i pulse stores one word per transmitter. The word is moved to the shifter at the start of the next slot that transmitter owns, and tx_load_o pulses in that cycle.
- R10: If a slot the transmitter owns starts with no new word written, the transmitter repeats its last word and pulses tx_urun_o instead of tx_load_o.
- R11: At each enabled received word, rx_valid_o pulses for one cycle with rx_word_o and rx_slot_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| net_mode_i | input | 1 | 1: network (multi-slot) frames, 0: normal frames |
| async_i | input | 1 | 1: transmit side uses its own clock and sync pins |
| wlen_sel_i | input | 2 | Word length select |
| last_slot_i | input | 5 | Number of the last slot in a network frame |
| tx_en_i | input | 3 | Transmitter enables |
| tx_mask_i | input | 96 | Slot masks of the transmitters, 32 bits each |
| rx_mask_i | input | 32 | Slot mask of the receiver |
| rx_sck_i | input | 1 | Receive (and synchronous) bit clock |
| rx_fs_i | input | 1 | Receive (and synchronous) frame sync |
| rx_sd_i | input | 1 | Receive serial data |
| tx_sck_i | input | 1 | Transmit bit clock in asynchronous mode |
| tx_fs_i | input | 1 | Transmit frame sync in asynchronous mode |
| tx_wr_i | input | 3 | Write strobes of the holding words |
| tx_wdata_i | input | 72 | Holding-word data, 24 bits per transmitter |
| tx_sd_o | output | 3 | Transmit serial data |
| tx_oe_o | output | 3 | Transmit output enables (0 = high impedance) |
| tx_load_o | output | 3 | Pulse: holding word taken into the shifter |
| tx_urun_o | output | 3 | Pulse: slot started without a new word |
| rx_valid_o | output | 1 | Pulse: received word ready |
| rx_word_o | output | 24 | Received word, right-aligned |
| rx_slot_o | output | 5 | Slot number of the received word |

## Verification
Some rules are checked on every cycle. The bit and slot counters stay inside the configured word length and frame length. A transmit line changes only on a bit-clock rising edge. A disabled transmitter never enables its output. A received word is reported only after a sampling edge, only in a slot its mask allows, and only in slot 0 in normal mode. The bench scenarios show what a single cycle cannot: the exact bit order and position after the frame sync, which word is repeated on an underrun, a word written earlier being kept until the next owned slot, and which clock pins each channel mode listens to.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int WL_W = 5;

  function automatic logic [WL_W-1:0] wlen_decode(input logic [1:0] sel);
    case (sel)
      2'd0:    wlen_decode = WL_W'(8);
      2'd1:    wlen_decode = WL_W'(16);
      default: wlen_decode = WL_W'(24);
    endcase
  endfunction
endpackage

// File: rtl/tdm_slot_ctr.sv
module tdm_slot_ctr #(
  parameter int WL_W   = 5,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              start_i,
  input  logic [WL_W-1:0]   wl_i,
  input  logic [SLOT_W-1:0] last_i,
  output logic              hbit_o,
  output logic              stop_o,
  output logic [WL_W-1:0]   nbit_o,
  output logic [SLOT_W-1:0] nslot_o
);
  logic              pend_q, act_q;
  logic [WL_W-1:0]   cbit_q;
  logic [SLOT_W-1:0] cslot_q;
  logic              word_end, frame_end;

  always_comb begin
    word_end  = (cbit_q == wl_i - 1'b1);
    frame_end = word_end && (cslot_q == last_i);
    hbit_o    = step_i && (pend_q || (act_q && !frame_end));
    stop_o    = step_i && !pend_q && act_q && frame_end;
    nbit_o    = (pend_q || word_end) ? '0 : cbit_q + 1'b1;
    nslot_o   = pend_q ? '0 : (word_end ? cslot_q + 1'b1 : cslot_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      act_q   <= 1'b0;
      cbit_q  <= '0;
      cslot_q <= '0;
    end else begin
      if (hbit_o) begin
        cbit_q  <= nbit_o;
        cslot_q <= nslot_o;
        act_q   <= 1'b1;
      end else if (stop_o) begin
        act_q <= 1'b0;
      end
      pend_q <= start_i ? 1'b1 : (step_i ? 1'b0 : pend_q);
    end
  end

  assert_bit_in_word_R3: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (cbit_q < wl_i));
  assert_slot_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (cslot_q <= last_i));
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane #(
  parameter int W    = 24,
  parameter int WL_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en_i,
  input  logic            slot_en_i,
  input  logic            hbit_i,
  input  logic            stop_i,
  input  logic [WL_W-1:0] nbit_i,
  input  logic [WL_W-1:0] wl_i,
  input  logic            wr_i,
  input  logic [W-1:0]    wdata_i,
  output logic            sd_o,
  output logic            oe_o,
  output logic            load_o,
  output logic            urun_o
);
  localparam logic [WL_W-1:0] WMAX = WL_W'(W);

  logic [W-1:0] hold_q, last_q, sh_q, word_sel, aligned;
  logic         hv_q, sd_q, oe_q, load_q, urun_q, take;

  always_comb begin
    word_sel = hv_q ? hold_q : last_q;
    aligned  = word_sel << (WMAX - wl_i);
    take     = hbit_i && (nbit_i == '0) && en_i && slot_en_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0; last_q <= '0; sh_q <= '0; hv_q <= 1'b0;
      sd_q <= 1'b0; oe_q <= 1'b0; load_q <= 1'b0; urun_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      urun_q <= 1'b0;
      if (take) begin
        oe_q   <= 1'b1;
        sd_q   <= aligned[W-1];
        sh_q   <= aligned << 1;
        last_q <= word_sel;
        load_q <= hv_q;
        urun_q <= !hv_q;
      end else if (hbit_i && (nbit_i != '0) && oe_q && en_i) begin
        sd_q <= sh_q[W-1];
        sh_q <= sh_q << 1;
      end else if (hbit_i || stop_i || !en_i) begin
        oe_q <= 1'b0;
        sd_q <= 1'b0;
      end
      if (wr_i) begin
        hold_q <= wdata_i;
        hv_q   <= 1'b1;
      end else if (take) begin
        hv_q <= 1'b0;
      end
    end
  end

  assign sd_o   = sd_q;
  assign oe_o   = oe_q;
  assign load_o = load_q;
  assign urun_o = urun_q;

  assert_sd_only_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(hbit_i) && !$past(stop_i) && $past(en_i)) |-> $stable(sd_q));
  assert_disabled_lane_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!en_i) |-> !oe_q);
  assert_load_xor_urun_R10: assert property (@(posedge clk) disable iff (rst)
    !(load_q && urun_q));
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane #(
  parameter int W      = 24,
  parameter int WL_W   = 5,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hbit_i,
  input  logic              stop_i,
  input  logic [WL_W-1:0]   nbit_i,
  input  logic [SLOT_W-1:0] nslot_i,
  input  logic [WL_W-1:0]   wl_i,
  input  logic              slot_en_i,
  input  logic              sd_i,
  output logic              valid_o,
  output logic [W-1:0]      word_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [W-1:0]      sh_q, word_q, nxt_sh, wmask;
  logic [SLOT_W-1:0] slot_q;
  logic              valid_q;

  always_comb begin
    nxt_sh = {sh_q[W-2:0], sd_i};
    wmask  = ~({W{1'b1}} << wl_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0; word_q <= '0; slot_q <= '0; valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (hbit_i) begin
        sh_q <= nxt_sh;
        if ((nbit_i == wl_i - 1'b1) && slot_en_i) begin
          valid_q <= 1'b1;
          word_q  <= nxt_sh & wmask;
          slot_q  <= nslot_i;
        end
      end else if (stop_i) begin
        sh_q <= '0;
      end
    end
  end

  assign valid_o = valid_q;
  assign word_o  = word_q;
  assign slot_o  = slot_q;

  assert_rx_after_sample_R2: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> $past(hbit_i));
endmodule

// File: rtl/tdm_serial_port.sv
module tdm_serial_port #(
  parameter int NUM_TX    = 3,
  parameter int MAX_SLOTS = 32,
  parameter int MAX_W     = 24
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          net_mode_i,
  input  logic                          async_i,
  input  logic [1:0]                    wlen_sel_i,
  input  logic [$clog2(MAX_SLOTS)-1:0]  last_slot_i,
  input  logic [NUM_TX-1:0]             tx_en_i,
  input  logic [NUM_TX*MAX_SLOTS-1:0]   tx_mask_i,
  input  logic [MAX_SLOTS-1:0]          rx_mask_i,
  input  logic                          rx_sck_i,
  input  logic                          rx_fs_i,
  input  logic                          rx_sd_i,
  input  logic                          tx_sck_i,
  input  logic                          tx_fs_i,
  input  logic [NUM_TX-1:0]             tx_wr_i,
  input  logic [NUM_TX*MAX_W-1:0]       tx_wdata_i,
  output logic [NUM_TX-1:0]             tx_sd_o,
  output logic [NUM_TX-1:0]             tx_oe_o,
  output logic [NUM_TX-1:0]             tx_load_o,
  output logic [NUM_TX-1:0]             tx_urun_o,
  output logic                          rx_valid_o,
  output logic [MAX_W-1:0]              rx_word_o,
  output logic [$clog2(MAX_SLOTS)-1:0]  rx_slot_o
);
  import tdm_pkg::*;

  localparam int SLOT_W = $clog2(MAX_SLOTS);

  logic              rx_sck_q, tx_sck_q;
  logic              rx_rise, rx_fall, tx_rise, tx_fall;
  logic              tx_step, tx_start, rx_start;
  logic [WL_W-1:0]   wl;
  logic [SLOT_W-1:0] eff_last;
  logic              tx_hbit, tx_stop, rx_hbit, rx_stop;
  logic [WL_W-1:0]   tx_nbit, rx_nbit;
  logic [SLOT_W-1:0] tx_nslot, rx_nslot;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sck_q <= 1'b0;
      tx_sck_q <= 1'b0;
    end else begin
      rx_sck_q <= rx_sck_i;
      tx_sck_q <= tx_sck_i;
    end
  end

  always_comb begin
    rx_rise  = rx_sck_i && !rx_sck_q;
    rx_fall  = !rx_sck_i && rx_sck_q;
    tx_rise  = tx_sck_i && !tx_sck_q;
    tx_fall  = !tx_sck_i && tx_sck_q;
    tx_step  = async_i ? tx_rise : rx_rise;
    tx_start = async_i ? (tx_fall && tx_fs_i) : (rx_fall && rx_fs_i);
    rx_start = rx_fall && rx_fs_i;
    wl       = wlen_decode(wlen_sel_i);
    eff_last = net_mode_i ? last_slot_i : '0;
  end

  tdm_slot_ctr #(.WL_W(WL_W), .SLOT_W(SLOT_W)) tx_ctr_i (
    .clk(clk), .rst(rst), .step_i(tx_step), .start_i(tx_start),
    .wl_i(wl), .last_i(eff_last), .hbit_o(tx_hbit), .stop_o(tx_stop),
    .nbit_o(tx_nbit), .nslot_o(tx_nslot));

  tdm_slot_ctr #(.WL_W(WL_W), .SLOT_W(SLOT_W)) rx_ctr_i (
    .clk(clk), .rst(rst), .step_i(rx_fall), .start_i(rx_start),
    .wl_i(wl), .last_i(eff_last), .hbit_o(rx_hbit), .stop_o(rx_stop),
    .nbit_o(rx_nbit), .nslot_o(rx_nslot));

  for (genvar k = 0; k < NUM_TX; k++) begin : g_tx
    logic                 lane_en, slot_en;
    logic [MAX_SLOTS-1:0] mask_k;
    if (k == 0) begin : g_first
      assign lane_en = tx_en_i[k];
    end else begin : g_rest
      assign lane_en = tx_en_i[k] && !async_i;
    end
    assign mask_k  = tx_mask_i[k*MAX_SLOTS +: MAX_SLOTS];
    assign slot_en = !net_mode_i || mask_k[tx_nslot];

    tdm_tx_lane #(.W(MAX_W), .WL_W(WL_W)) lane_i (
      .clk(clk), .rst(rst), .en_i(lane_en), .slot_en_i(slot_en),
      .hbit_i(tx_hbit), .stop_i(tx_stop), .nbit_i(tx_nbit), .wl_i(wl),
      .wr_i(tx_wr_i[k]), .wdata_i(tx_wdata_i[k*MAX_W +: MAX_W]),
      .sd_o(tx_sd_o[k]), .oe_o(tx_oe_o[k]), .load_o(tx_load_o[k]),
      .urun_o(tx_urun_o[k]));
  end

  tdm_rx_lane #(.W(MAX_W), .WL_W(WL_W), .SLOT_W(SLOT_W)) rx_lane_i (
    .clk(clk), .rst(rst), .hbit_i(rx_hbit), .stop_i(rx_stop),
    .nbit_i(rx_nbit), .nslot_i(rx_nslot), .wl_i(wl),
    .slot_en_i(!net_mode_i || rx_mask_i[rx_nslot]), .sd_i(rx_sd_i),
    .valid_o(rx_valid_o), .word_o(rx_word_o), .slot_o(rx_slot_o));

  assert_rx_mask_honoured_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_o && net_mode_i) |-> rx_mask_i[rx_slot_o]);
  assert_normal_only_slot0_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_o && !net_mode_i) |-> (rx_slot_o == '0));
endmodule

// File: tb/tdm_serial_port_tb.sv
module tdm_serial_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        net = 1'b0, asy = 1'b0;
  logic [1:0]  wsel = 2'd2;
  logic [4:0]  lastsl = '0;
  logic [2:0]  tx_en = '0;
  logic [95:0] tx_mask = '0;
  logic [31:0] rx_mask = '0;
  logic        rx_sck = 1'b0, rx_fs = 1'b0, rx_sd = 1'b0;
  logic        tx_sck = 1'b0, tx_fs = 1'b0;
  logic [2:0]  tx_wr = '0;
  logic [71:0] tx_wdata = '0;
  logic [2:0]  tx_sd, tx_oe, tx_load, tx_urun;
  logic        rx_valid;
  logic [23:0] rx_word;
  logic [4:0]  rx_slot;

  always #2 clk = ~clk;

  tdm_serial_port dut_i (
    .clk(clk), .rst(rst), .net_mode_i(net), .async_i(asy), .wlen_sel_i(wsel),
    .last_slot_i(lastsl), .tx_en_i(tx_en), .tx_mask_i(tx_mask), .rx_mask_i(rx_mask),
    .rx_sck_i(rx_sck), .rx_fs_i(rx_fs), .rx_sd_i(rx_sd), .tx_sck_i(tx_sck),
    .tx_fs_i(tx_fs), .tx_wr_i(tx_wr), .tx_wdata_i(tx_wdata), .tx_sd_o(tx_sd),
    .tx_oe_o(tx_oe), .tx_load_o(tx_load), .tx_urun_o(tx_urun),
    .rx_valid_o(rx_valid), .rx_word_o(rx_word), .rx_slot_o(rx_slot));

  int checks = 0, bad = 0;
  bit done = 1'b0;

  bit          hv_m [3];
  logic [23:0] hold_m [3];
  logic [23:0] last_m [3];
  logic [23:0] cur_m [3];
  logic [23:0] wq [3][$];
  logic [23:0] rx_words [32];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_word(input int k, input logic [23:0] d);
    tx_wdata[k*24 +: 24] = d;
    tx_wr[k] = 1'b1;
    hv_m[k] = 1'b1;
    hold_m[k] = d;
  endtask

  task automatic one_bit(input bit use_tx, input bit fs, input bit d, input int s,
                         input int b, input int wl, input int nsl);
    bit data;
    bit so [3];
    data = (s >= 0) && (s < nsl);
    @(negedge clk);
    if (use_tx) begin tx_sck = 1'b1; tx_fs = fs; end
    else begin rx_sck = 1'b1; rx_fs = fs; rx_sd = d; end
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      bit lane_on, el, eu, eo, es;
      lane_on = tx_en[k] && (!asy || k == 0) && (use_tx == asy);
      so[k] = lane_on && data && (!net || tx_mask[k*32 + s]);
      el = 1'b0; eu = 1'b0;
      if (so[k] && b == 0) begin
        el = hv_m[k]; eu = !hv_m[k];
        cur_m[k] = hv_m[k] ? hold_m[k] : last_m[k];
        last_m[k] = cur_m[k];
        hv_m[k] = 1'b0;
      end
      eo = so[k];
      es = so[k] ? cur_m[k][wl-1-b] : 1'b0;
      chk(tx_oe[k] == eo, "R6 tx output enable per slot", 32'(tx_oe[k]), 32'(eo));
      chk(tx_sd[k] == es, "R2 tx bit order msb-first", 32'(tx_sd[k]), 32'(es));
      chk(tx_load[k] == el, "R9 load pulse", 32'(tx_load[k]), 32'(el));
      chk(tx_urun[k] == eu, "R10 underrun pulse", 32'(tx_urun[k]), 32'(eu));
    end
    @(negedge clk);
    if (use_tx) tx_sck = 1'b0; else rx_sck = 1'b0;
    for (int k = 0; k < 3; k++)
      if (so[k] && b == 0 && wq[k].size() > 0 && !hv_m[k]) wr_word(k, wq[k].pop_front());
    @(negedge clk);
    tx_wr = '0;
    begin
      bit ev;
      logic [23:0] ew;
      ev = !use_tx && data && (b == wl - 1) && (!net || rx_mask[s]);
      chk(rx_valid == ev, "R11 rx valid pulse", 32'(rx_valid), 32'(ev));
      if (ev) begin
        ew = rx_words[s] & ((24'h1 << wl) - 24'h1);
        if (wl == 24) ew = rx_words[s];
        chk(rx_word == ew, "R3 rx word right-aligned", 32'(rx_word), 32'(ew));
        chk(rx_slot == 5'(s), "R5 rx slot number", 32'(rx_slot), s);
      end
    end
  endtask

  task automatic frame(input bit use_tx, input int wl, input int nsl);
    one_bit(use_tx, 1'b1, 1'b0, -1, 0, wl, nsl);
    for (int s = 0; s < nsl; s++)
      for (int b = 0; b < wl; b++)
        one_bit(use_tx, 1'b0, rx_words[s][wl-1-b], s, b, wl, nsl);
    one_bit(use_tx, 1'b0, 1'b0, nsl, 0, wl, nsl);
  endtask

  task automatic pulse_write(input int k, input logic [23:0] d);
    @(negedge clk);
    wr_word(k, d);
    @(negedge clk);
    tx_wr = '0;
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin
      hv_m[k] = 1'b0; hold_m[k] = '0; last_m[k] = '0; cur_m[k] = '0;
    end
    for (int s = 0; s < 32; s++) rx_words[s] = 24'(s * 24'h2F1D3 + 24'h5A);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(tx_oe == '0, "R1 reset oe", 32'(tx_oe), 0);
    chk(tx_sd == '0, "R1 reset sd", 32'(tx_sd), 0);
    chk((tx_load | tx_urun) == '0, "R1 reset pulses", 32'(tx_load | tx_urun), 0);
    chk(rx_valid == 1'b0, "R1 reset rx valid", 32'(rx_valid), 0);

    // R4 R3 R9: normal mode, 24-bit, masks clear yet slot 0 still active
    net = 0; asy = 0; wsel = 2'd2; tx_en = 3'b001; tx_mask = '0; rx_mask = '0;
    rx_words[0] = 24'h3C96F1;
    pulse_write(0, 24'hA5C31E);
    frame(1'b0, 24, 1);

    // R7 R10 R3: 8-bit, all three transmitters, tx0 underruns
    wsel = 2'd0; tx_en = 3'b111;
    rx_words[0] = 24'h000081;
    pulse_write(1, 24'h00005A);
    pulse_write(2, 24'h0000C3);
    frame(1'b0, 8, 1);

    // R5 R6: network, 16-bit, four slots, refills mid-frame
    net = 1; wsel = 2'd1; lastsl = 5'd3;
    tx_mask = '0;
    tx_mask[0*32 +: 32] = 32'h5;
    tx_mask[1*32 +: 32] = 32'h2;
    tx_mask[2*32 +: 32] = 32'h8;
    rx_mask = 32'hB;
    pulse_write(0, 24'h001234);
    pulse_write(1, 24'h000F0F);
    pulse_write(2, 24'h00AAAA);
    wq[0].push_back(24'h00BEEF);
    frame(1'b0, 16, 4);

    // R5 R6: 32 slots, only the last one owned
    wsel = 2'd0; lastsl = 5'd31; tx_en = 3'b001;
    tx_mask = '0; tx_mask[31] = 1'b1; rx_mask = 32'h8000_0000;
    frame(1'b0, 8, 32);

    // R8: asynchronous mode, transmit pins only, tx1 written but silent
    net = 0; asy = 1; tx_en = 3'b111; lastsl = '0;
    pulse_write(0, 24'h00003D);
    pulse_write(1, 24'h000077);
    frame(1'b1, 8, 1);

    // R7: synchronous mode ignores the transmit clock pins
    asy = 0;
    frame(1'b1, 8, 1);

    // R9: word held since the async frame goes out in the next owned slot
    tx_en = 3'b010;
    frame(1'b0, 8, 1);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule